// File: doc/BRIEF.md
# Synchronisation Timer with Register Access

A free-running 64-bit microsecond timer reached by software as a pair of 32-bit registers on a plain write-strobe / read-address register bus. The timer advances by one on every single-cycle microsecond tick. Software loads a new timer value in two bus writes. The low word is parked in a shadow register, and the whole 64-bit value lands in one clock edge when the high word is written. A command register clears the timer in a single edge. A status bit shows that a load or clear was applied in the last two cycles.

The block also drives a quiet-window output from the timer. Software programs a first start time and a repeat period, both in 1024-microsecond time units, and a window length in microsecond ticks. While the quiet function is enabled, the window opens when the low 32 timer bits equal the next start time. The next start time then moves forward by one period. Clearing the enable bit closes an open window at once.

A reader that needs a consistent 64-bit value reads low, high, then low again. If the second low read is smaller than the first, the reader adds one to the high word.

Top module: `sync_timer_top`

## Requirements
- R1: After reset the timer reads 0 at both TIME_LO (address 0) and TIME_HI (address 1), STATUS (address 3) bit 0 reads 0, and `quiet_o` is 0.
- R2: A write to TIME_LO (address 0) only stores the value in a shadow register. The running timer does not change and keeps counting ticks.
- R3: A write to TIME_HI (address 1) loads the timer with {write data, shadow} at that clock edge. A tick in the same cycle is ignored.
- R4: Each cycle with `us_tick` high and no load or clear adds one to the 64-bit timer, and the carry passes from bit 31 into the high word.
- R5: A write to CLEAR (address 2) with data bit 0 set zeroes the timer at that edge. A write to CLEAR with bit 0 clear has no effect.
- R6: STATUS (address 3) bit 0 reads 1 during the two cycles that follow the edge of a TIME_HI load or a clear, and reads 0 after that.
- R7: Writing QSTART (address 4) sets the next start time to the write data shifted left by 10. Writing QPERIOD (address 5) sets the period in the same 1024 µs units. Writing QLEN (address 6) sets the window length in ticks. QCTRL (address 7) bit 0 is the enable.
- R8: While enabled, a cycle in which the low timer word equals the next start time raises `quiet_o` at the following edge. `quiet_o` then stays high for QLEN further ticks.
- R9: When a window opens, the next start time, read back at address 4 in microseconds, advances by the period shifted left by 10.
- R10: A write to QCTRL with bit 0 clear drops `quiet_o` at that write's edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | Single-cycle microsecond tick |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| quiet_o | output | 1 | Quiet window active |

## Verification
Read data is combinational from registers. A write or tick applied in one cycle is therefore visible on `bus_rdata` at the next falling edge, and the bench samples there. The status bit is due high at the first and second falling edges after a load or clear, and low at the third; the bench reads it at exactly those points. `quiet_o` rises one edge after the edge on which the timer reaches the start value, so the bench samples it one idle cycle after the tick that makes the match. It counts the window length one tick at a time, and the disable is sampled at the falling edge right after the write.

// File: rtl/sync_timer_pkg.sv
package sync_timer_pkg;
    localparam int ADDR_W   = 3;
    localparam int TU_SHIFT = 10;

    typedef enum logic [ADDR_W-1:0] {
        REG_TIME_LO = 3'd0,
        REG_TIME_HI = 3'd1,
        REG_CLEAR   = 3'd2,
        REG_STATUS  = 3'd3,
        REG_QSTART  = 3'd4,
        REG_QPERIOD = 3'd5,
        REG_QLEN    = 3'd6,
        REG_QCTRL   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic lo;
        logic hi;
        logic clr;
        logic start;
        logic period;
        logic len;
        logic ctrl;
    } wr_strobe_t;

    function automatic logic [31:0] tu_to_us(input logic [31:0] tu);
        return tu << TU_SHIFT;
    endfunction
endpackage

// File: rtl/sync_timer_decode.sv
module sync_timer_decode
    import sync_timer_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output wr_strobe_t        strb
);
    always_comb begin
        strb        = '0;
        if (wr) begin
            unique case (reg_sel_e'(addr))
                REG_TIME_LO: strb.lo     = 1'b1;
                REG_TIME_HI: strb.hi     = 1'b1;
                REG_CLEAR:   strb.clr    = wdata[0];
                REG_QSTART:  strb.start  = 1'b1;
                REG_QPERIOD: strb.period = 1'b1;
                REG_QLEN:    strb.len    = 1'b1;
                REG_QCTRL:   strb.ctrl   = 1'b1;
                default:     strb        = '0;
            endcase
        end
    end
endmodule

// File: rtl/sync_timer_core.sv
module sync_timer_core #(
    parameter int BUS_W    = 32,
    parameter int BUSY_CYC = 2,
    localparam int TIMER_W = 2 * BUS_W,
    localparam int BC_W    = $clog2(BUSY_CYC + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               ld_lo,
    input  logic               ld_hi,
    input  logic               clr,
    input  logic [BUS_W-1:0]   wdata,
    output logic [TIMER_W-1:0] timer_q,
    output logic               busy
);
    logic [BUS_W-1:0] shadow_q;
    logic [BC_W-1:0]  busy_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q  <= '0;
            shadow_q <= '0;
            busy_cnt <= '0;
        end else begin
            if (ld_lo)
                shadow_q <= wdata;
            if (clr)
                timer_q <= '0;
            else if (ld_hi)
                timer_q <= {wdata, shadow_q};
            else if (tick)
                timer_q <= timer_q + 1'b1;
            if (clr || ld_hi)
                busy_cnt <= BC_W'(BUSY_CYC);
            else if (busy_cnt != '0)
                busy_cnt <= busy_cnt - 1'b1;
        end
    end

    assign busy = (busy_cnt != '0);
endmodule

// File: rtl/sync_timer_quiet.sv
module sync_timer_quiet
    import sync_timer_pkg::*;
#(
    parameter int BUS_W = 32,
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [BUS_W-1:0] time_lo,
    input  wr_strobe_t       strb,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] next_us,
    output logic [BUS_W-1:0] period_tu,
    output logic [LEN_W-1:0] len_q,
    output logic             enable,
    output logic             quiet
);
    logic [LEN_W-1:0] remain;
    logic             hit;

    assign hit = enable && (time_lo == next_us);

    always_ff @(posedge clk) begin
        if (rst) begin
            next_us   <= '0;
            period_tu <= '0;
            len_q     <= '0;
            enable    <= 1'b0;
            remain    <= '0;
        end else begin
            if (strb.period)
                period_tu <= wdata;
            if (strb.len)
                len_q <= wdata[LEN_W-1:0];
            if (strb.ctrl)
                enable <= wdata[0];

            if (strb.ctrl && !wdata[0])
                remain <= '0;
            else if (hit)
                remain <= len_q;
            else if (tick && remain != '0)
                remain <= remain - 1'b1;

            if (strb.start)
                next_us <= tu_to_us(wdata);
            else if (hit)
                next_us <= next_us + tu_to_us(period_tu);
        end
    end

    assign quiet = (remain != '0);
endmodule

// File: rtl/sync_timer_top.sv
module sync_timer_top
    import sync_timer_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int LEN_W    = 16,
    parameter int BUSY_CYC = 2,
    localparam int TIMER_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              us_tick,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              quiet_o
);
    wr_strobe_t         strb;
    logic [TIMER_W-1:0] timer_q;
    logic               busy;
    logic [BUS_W-1:0]   next_us;
    logic [BUS_W-1:0]   period_tu;
    logic [LEN_W-1:0]   len_q;
    logic               enable;

    sync_timer_decode #(.BUS_W(BUS_W)) u_dec (
        .wr    (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .strb  (strb)
    );

    sync_timer_core #(.BUS_W(BUS_W), .BUSY_CYC(BUSY_CYC)) u_core (
        .clk     (clk),
        .rst     (rst),
        .tick    (us_tick),
        .ld_lo   (strb.lo),
        .ld_hi   (strb.hi),
        .clr     (strb.clr),
        .wdata   (bus_wdata),
        .timer_q (timer_q),
        .busy    (busy)
    );

    sync_timer_quiet #(.BUS_W(BUS_W), .LEN_W(LEN_W)) u_quiet (
        .clk       (clk),
        .rst       (rst),
        .tick      (us_tick),
        .time_lo   (timer_q[BUS_W-1:0]),
        .strb      (strb),
        .wdata     (bus_wdata),
        .next_us   (next_us),
        .period_tu (period_tu),
        .len_q     (len_q),
        .enable    (enable),
        .quiet     (quiet_o)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_TIME_LO: bus_rdata = timer_q[BUS_W-1:0];
            REG_TIME_HI: bus_rdata = timer_q[TIMER_W-1:BUS_W];
            REG_STATUS:  bus_rdata = {{(BUS_W-1){1'b0}}, busy};
            REG_QSTART:  bus_rdata = next_us;
            REG_QPERIOD: bus_rdata = period_tu;
            REG_QLEN:    bus_rdata = {{(BUS_W-LEN_W){1'b0}}, len_q};
            REG_QCTRL:   bus_rdata = {{(BUS_W-1){1'b0}}, enable};
            default:     bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/sync_timer_chk.sv
module sync_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        us_tick,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [63:0] timer_q,
    input logic        busy,
    input logic        quiet_o
);
    logic wr_hi, wr_clr, wr_lo, wr_off;
    assign wr_lo  = bus_wr && bus_addr == 3'd0;
    assign wr_hi  = bus_wr && bus_addr == 3'd1;
    assign wr_clr = bus_wr && bus_addr == 3'd2 && bus_wdata[0];
    assign wr_off = bus_wr && bus_addr == 3'd7 && !bus_wdata[0];

    a_r2_low_staged: assert property (@(posedge clk) disable iff (rst)
        (wr_lo && !us_tick) |=> $stable(timer_q));

    a_r3_commit_high: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> timer_q[63:32] == $past(bus_wdata));

    a_r4_tick_step: assert property (@(posedge clk) disable iff (rst)
        (us_tick && !wr_hi && !wr_clr) |=> timer_q == $past(timer_q) + 64'd1);

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        wr_clr |=> timer_q == 64'd0);

    a_r6_busy_first: assert property (@(posedge clk) disable iff (rst)
        (wr_hi || wr_clr) |=> busy);

    a_r6_busy_second: assert property (@(posedge clk) disable iff (rst)
        (wr_hi || wr_clr) |=> ##1 busy);

    a_r10_disable_now: assert property (@(posedge clk) disable iff (rst)
        wr_off |=> !quiet_o);
endmodule

bind sync_timer_top sync_timer_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .us_tick   (us_tick),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .timer_q   (timer_q),
    .busy      (busy),
    .quiet_o   (quiet_o)
);

// File: tb/sync_timer_top_tb.sv
module sync_timer_top_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 26;
    // kind: 0 write, 1 read-check, 2 tick, 3 write with tick
    localparam logic [72:0] VEC [NVEC] = '{
        {4'd2,  2'd0, 3'd0, 32'h0000_1234, 32'h0},         // R2 stage low
        {4'd2,  2'd1, 3'd0, 32'h0,         32'h0},         // R2 low unchanged
        {4'd2,  2'd1, 3'd1, 32'h0,         32'h0},         // R2 high unchanged
        {4'd3,  2'd0, 3'd1, 32'h0000_0005, 32'h0},         // R3 commit
        {4'd6,  2'd1, 3'd3, 32'h0,         32'h1},         // R6 busy cycle 1
        {4'd6,  2'd1, 3'd3, 32'h0,         32'h1},         // R6 busy cycle 2
        {4'd6,  2'd1, 3'd3, 32'h0,         32'h0},         // R6 ready
        {4'd3,  2'd1, 3'd0, 32'h0,         32'h0000_1234}, // R3 low
        {4'd3,  2'd1, 3'd1, 32'h0,         32'h0000_0005}, // R3 high
        {4'd4,  2'd2, 3'd0, 32'h0,         32'h0},         // R4 tick
        {4'd4,  2'd1, 3'd0, 32'h0,         32'h0000_1235}, // R4 step
        {4'd4,  2'd0, 3'd0, 32'hFFFF_FFFF, 32'h0},         // R4 rollover setup
        {4'd4,  2'd0, 3'd1, 32'h0000_0007, 32'h0},
        {4'd4,  2'd2, 3'd0, 32'h0,         32'h0},
        {4'd4,  2'd1, 3'd0, 32'h0,         32'h0},         // R4 low wraps
        {4'd4,  2'd1, 3'd1, 32'h0,         32'h0000_0008}, // R4 carry in high
        {4'd5,  2'd0, 3'd2, 32'h0000_0001, 32'h0},         // R5 clear
        {4'd6,  2'd1, 3'd3, 32'h0,         32'h1},         // R6 busy after clear
        {4'd5,  2'd1, 3'd0, 32'h0,         32'h0},
        {4'd5,  2'd1, 3'd1, 32'h0,         32'h0},         // R5 high cleared
        {4'd5,  2'd0, 3'd0, 32'h0000_0050, 32'h0},
        {4'd5,  2'd0, 3'd1, 32'h0,         32'h0},
        {4'd5,  2'd0, 3'd2, 32'h0000_0002, 32'h0},         // R5 bit0 clear ignored
        {4'd5,  2'd1, 3'd0, 32'h0,         32'h0000_0050},
        {4'd3,  2'd0, 3'd0, 32'h0000_0100, 32'h0},         // R3 tick vs commit
        {4'd3,  2'd3, 3'd1, 32'h0,         32'h0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        us_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        quiet_o;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sync_timer_top u_dut (
        .clk(clk), .rst(rst), .us_tick(us_tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .quiet_o(quiet_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic tick_pair;
        @(negedge clk); us_tick = 1'b1;
        @(negedge clk); us_tick = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd("R1", 3'd0, 32'h0);
        rd("R1", 3'd1, 32'h0);
        rd("R1", 3'd3, 32'h0);
        check("R1", {31'h0, quiet_o}, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            bus_wr = 1'b0; us_tick = 1'b0;
            bus_addr  = VEC[i][66:64];
            bus_wdata = VEC[i][63:32];
            case (VEC[i][68:67])
                2'd0: bus_wr = 1'b1;
                2'd1: begin
                    #1;
                    checks++;
                    if (bus_rdata !== VEC[i][31:0]) begin
                        fails++;
                        $display("FAIL R%0d vector %0d actual=%h expected=%h",
                                 VEC[i][72:69], i, bus_rdata, VEC[i][31:0]);
                    end
                end
                2'd2: us_tick = 1'b1;
                default: begin bus_wr = 1'b1; us_tick = 1'b1; end
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0; us_tick = 1'b0;
        rd("R3", 3'd0, 32'h0000_0100); // tick in commit cycle ignored

        // Quiet window programming (R7)
        wr(3'd0, 32'h0000_03FE);
        wr(3'd1, 32'h0);
        wr(3'd5, 32'h1);
        wr(3'd6, 32'h3);
        wr(3'd4, 32'h1);
        wr(3'd7, 32'h1);
        rd("R7", 3'd4, 32'h0000_0400);
        rd("R7", 3'd6, 32'h3);
        rd("R7", 3'd7, 32'h1);
        tick_pair();
        check("R8", {31'h0, quiet_o}, 32'h0);
        tick_pair();
        check("R8", {31'h0, quiet_o}, 32'h1);
        rd("R9", 3'd4, 32'h0000_0800);
        tick_pair();
        check("R8", {31'h0, quiet_o}, 32'h1);
        tick_pair();
        check("R8", {31'h0, quiet_o}, 32'h1);
        tick_pair();
        check("R8", {31'h0, quiet_o}, 32'h0);

        // R10 disable closes an open window
        wr(3'd0, 32'h0000_07FF);
        wr(3'd1, 32'h0);
        tick_pair();
        check("R8", {31'h0, quiet_o}, 32'h1);
        rd("R9", 3'd4, 32'h0000_0C00);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd7; bus_wdata = 32'h0;
        @(negedge clk);
        bus_wr = 1'b0;
        check("R10", {31'h0, quiet_o}, 32'h0);
        tick_pair();
        check("R10", {31'h0, quiet_o}, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule